// File: doc/BRIEF.md
# Sequential High/Low Integer Multiplier

This block multiplies two integer operands over a fixed number of clock cycles and returns one half of the double-width product. A request is placed by raising `start` while the block is idle. The request carries the two operands and three selects: whether the operands are signed, whether only their low halves take part (word form), and whether the upper or the lower half of the product is wanted. A fourth select picks an immediate form. In that form the second operand is a sign-extended 16-bit constant, the multiply is signed and low-half, and no flags are produced.

The datapath takes operand magnitudes and runs one shift-add step per cycle. It negates the double-width product at the end when the operand signs differ. A final stage formats the destination value and works out two flags. The overflow flag covers the low-half forms. The three-bit condition field always comes from a signed comparison of the result with zero, including the unsigned forms. The result and flags are registered and held until the next request completes. A one-cycle `done` pulse marks them valid.

Top module: `mul_hilo`

## Requirements
- R1: In word form (`is_word`=1), only bits [31:0] of each operand take part. They are sign-extended when `is_signed`=1 and zero-extended otherwise, giving a 64-bit product. The low-word form returns product bits [31:0] in result[31:0].
- R2: The high-word form returns product bits [63:32] in result[31:0]. In every word form, result[63:32] is zero.
- R3: The high-doubleword form returns bits [127:64] of the 128-bit product, signed or unsigned as selected.
- R4: The low-doubleword form returns bits [63:0] of the product. These bits are identical for signed and unsigned operands.
- R5: `ovf` is 1 for a low-half form when the product does not fit the result width: 32 bits for word, 64 for doubleword. Signed forms use the two's-complement range and unsigned forms the unsigned range. `ovf` is 0 for all high-half forms.
- R6: `cond` is {negative, positive, zero} in bits [2], [1], [0]. It compares the result with zero as a signed number: the sign-extended low 32 bits for word forms, all 64 bits for doubleword forms. It is exactly one-hot for every non-immediate form, including the unsigned high forms.
- R7: When `use_imm`=1, the block computes the low 64 bits of `src_a` times the sign-extended `imm_val`. `src_b`, `is_signed`, `is_word` and `want_high` are ignored, and `ovf` and `cond` are both 0.
- R8: A `start` accepted while idle gives a one-cycle `done` pulse 65 rising edges after the accepting edge (XLEN+1). `busy` is 1 from the accepting edge until `done` rises.
- R9: `start` while `busy`=1 is ignored. The running request completes with its own operands and its own latency.
- R10: `result`, `ovf` and `cond` change only on the edge that raises `done`, and hold their values otherwise.
- R11: During and after reset, `busy`, `done`, `result`, `ovf` and `cond` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, taken only when idle |
| is_signed | input | 1 | Operands are two's-complement |
| is_word | input | 1 | Use the low 32 bits of each operand |
| want_high | input | 1 | Return the upper product half |
| use_imm | input | 1 | Immediate form: second operand from `imm_val` |
| src_a | input | 64 | First operand |
| src_b | input | 64 | Second operand |
| imm_val | input | 16 | Immediate operand, sign-extended |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle pulse: result valid |
| result | output | 64 | Selected product half |
| ovf | output | 1 | Low-half overflow flag |
| cond | output | 3 | {negative, positive, zero} |

## Verification
The assertions assume the following about the inputs:
- Reset is held across at least one rising edge.
- Operands and selects matter only on the edge that accepts `start`.
- Whether a `start` is accepted follows solely from the `busy` output.

The stimulus raises `start` for one cycle from the falling edge, and only after observing `busy` low. It then deliberately raises `start` again with scrambled operands and selects while a request runs. Word forms carry random upper operand bits, and immediate forms carry a random `src_b`. The bench compares each result with a native wide multiply of the same operands.

// File: rtl/mul_pkg.sv
package mul_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } mul_state_e;

  // Request attributes latched when a start is accepted
  typedef struct packed {
    logic neg;   // product must be negated at the end
    logic sgn;   // signed interpretation
    logic word;  // low-half operand form
    logic high;  // upper product half wanted
    logic imm;   // immediate form
  } mul_ctrl_t;

endpackage

// File: rtl/mul_opprep.sv
module mul_opprep
  import mul_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int IMMW = 16
) (
  input  logic [XLEN-1:0] src_a,
  input  logic [XLEN-1:0] src_b,
  input  logic [IMMW-1:0] imm_val,
  input  logic            is_signed,
  input  logic            is_word,
  input  logic            want_high,
  input  logic            use_imm,
  output logic [XLEN-1:0] mag_a,
  output logic [XLEN-1:0] mag_b,
  output mul_ctrl_t       ctrl
);

  localparam int HALF = XLEN / 2;

  logic            sgn_e, word_e, high_e;
  logic [XLEN-1:0] ext_a, ext_b, imm_ext, b_sel;

  always_comb begin
    sgn_e   = use_imm | is_signed;
    word_e  = ~use_imm & is_word;
    high_e  = ~use_imm & want_high;
    imm_ext = {{(XLEN-IMMW){imm_val[IMMW-1]}}, imm_val};
    b_sel   = use_imm ? imm_ext : src_b;

    if (word_e) begin
      ext_a = {{HALF{sgn_e & src_a[HALF-1]}}, src_a[HALF-1:0]};
      ext_b = {{HALF{sgn_e & b_sel[HALF-1]}}, b_sel[HALF-1:0]};
    end else begin
      ext_a = src_a;
      ext_b = b_sel;
    end

    mag_a = (sgn_e & ext_a[XLEN-1]) ? -ext_a : ext_a;
    mag_b = (sgn_e & ext_b[XLEN-1]) ? -ext_b : ext_b;

    ctrl.neg  = sgn_e & (ext_a[XLEN-1] ^ ext_b[XLEN-1]);
    ctrl.sgn  = sgn_e;
    ctrl.word = word_e;
    ctrl.high = high_e;
    ctrl.imm  = use_imm;
  end

endmodule

// File: rtl/mul_shiftadd.sv
module mul_shiftadd #(
  parameter int XLEN = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [XLEN-1:0]   mcand,
  input  logic [XLEN-1:0]   mplier,
  output logic [2*XLEN-1:0] prod
);

  logic [XLEN-1:0] hi_q, hi_d;
  logic [XLEN-1:0] lo_q, lo_d;
  logic [XLEN-1:0] mc_q, mc_d;
  logic [XLEN:0]   sum;

  always_comb begin
    sum  = {1'b0, hi_q} + (lo_q[0] ? {1'b0, mc_q} : '0);
    hi_d = hi_q;
    lo_d = lo_q;
    mc_d = mc_q;
    if (load) begin
      hi_d = '0;
      lo_d = mplier;
      mc_d = mcand;
    end else if (step) begin
      {hi_d, lo_d} = {sum, lo_q[XLEN-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
      mc_q <= '0;
    end else if (load || step) begin
      hi_q <= hi_d;
      lo_q <= lo_d;
      mc_q <= mc_d;
    end
  end

  assign prod = {hi_q, lo_q};

endmodule

// File: rtl/mul_fmt.sv
module mul_fmt
  import mul_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [2*XLEN-1:0] prod,
  input  mul_ctrl_t         ctrl,
  output logic [XLEN-1:0]   res,
  output logic              ovf,
  output logic [2:0]        cond
);

  localparam int HALF = XLEN / 2;

  logic [2*XLEN-1:0] full;
  logic [XLEN-1:0]   cmp_v;
  logic              ovf_raw, lt, eq;

  always_comb begin
    full = ctrl.neg ? -prod : prod;

    if (ctrl.word) begin
      res = ctrl.high ? {{HALF{1'b0}}, full[XLEN-1:HALF]}
                      : {{HALF{1'b0}}, full[HALF-1:0]};
      if (ctrl.sgn)
        ovf_raw = !((&full[XLEN-1:HALF-1]) || !(|full[XLEN-1:HALF-1]));
      else
        ovf_raw = |full[XLEN-1:HALF];
      cmp_v = {{HALF{res[HALF-1]}}, res[HALF-1:0]};
    end else begin
      res = ctrl.high ? full[2*XLEN-1:XLEN] : full[XLEN-1:0];
      if (ctrl.sgn)
        ovf_raw = !((&full[2*XLEN-1:XLEN-1]) || !(|full[2*XLEN-1:XLEN-1]));
      else
        ovf_raw = |full[2*XLEN-1:XLEN];
      cmp_v = res;
    end

    ovf  = ovf_raw & ~ctrl.high & ~ctrl.imm;
    lt   = cmp_v[XLEN-1];
    eq   = (cmp_v == '0);
    cond = ctrl.imm ? 3'b000 : {lt, ~lt & ~eq, eq};
  end

endmodule

// File: rtl/mul_hilo.sv
module mul_hilo
  import mul_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int IMMW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            is_signed,
  input  logic            is_word,
  input  logic            want_high,
  input  logic            use_imm,
  input  logic [XLEN-1:0] src_a,
  input  logic [XLEN-1:0] src_b,
  input  logic [IMMW-1:0] imm_val,
  output logic            busy,
  output logic            done,
  output logic [XLEN-1:0] result,
  output logic            ovf,
  output logic [2:0]      cond
);

  localparam int CNTW = $clog2(XLEN);
  localparam logic [CNTW-1:0] LAST = CNTW'(XLEN - 1);

  mul_state_e        state_q, state_d;
  logic [CNTW-1:0]   cnt_q, cnt_d;
  mul_ctrl_t         ctrl_q, ctrl_d, prep_ctrl;
  logic [XLEN-1:0]   mag_a, mag_b;
  logic [2*XLEN-1:0] prod;
  logic [XLEN-1:0]   fmt_res;
  logic              fmt_ovf;
  logic [2:0]        fmt_cond;
  logic              accept, step, out_en, done_d;

  mul_opprep #(.XLEN(XLEN), .IMMW(IMMW)) u_prep (
    .src_a    (src_a),
    .src_b    (src_b),
    .imm_val  (imm_val),
    .is_signed(is_signed),
    .is_word  (is_word),
    .want_high(want_high),
    .use_imm  (use_imm),
    .mag_a    (mag_a),
    .mag_b    (mag_b),
    .ctrl     (prep_ctrl)
  );

  mul_shiftadd #(.XLEN(XLEN)) u_core (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept),
    .step  (step),
    .mcand (mag_a),
    .mplier(mag_b),
    .prod  (prod)
  );

  mul_fmt #(.XLEN(XLEN)) u_fmt (
    .prod(prod),
    .ctrl(ctrl_q),
    .res (fmt_res),
    .ovf (fmt_ovf),
    .cond(fmt_cond)
  );

  assign accept = start && (state_q == ST_IDLE);
  assign step   = (state_q == ST_RUN);
  assign out_en = (state_q == ST_FIN);

  // next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    ctrl_d  = ctrl_q;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (accept) begin
        state_d = ST_RUN;
        cnt_d   = '0;
        ctrl_d  = prep_ctrl;
      end
      ST_RUN: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == LAST) state_d = ST_FIN;
      end
      ST_FIN: begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      ctrl_q  <= '0;
      done    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      ctrl_q  <= ctrl_d;
      done    <= done_d;
    end
  end

  // output registers, enabled only in the finishing cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result <= '0;
      ovf    <= 1'b0;
      cond   <= 3'b000;
    end else if (out_en) begin
      result <= fmt_res;
      ovf    <= fmt_ovf;
      cond   <= fmt_cond;
    end
  end

  assign busy = (state_q != ST_IDLE);

endmodule

// File: rtl/mul_hilo_chk.sv
module mul_hilo_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            is_word,
  input logic            want_high,
  input logic            use_imm,
  input logic            busy,
  input logic            done,
  input logic [XLEN-1:0] result,
  input logic            ovf,
  input logic [2:0]      cond
);

  localparam int HALF = XLEN / 2;
  localparam int LW   = $clog2(XLEN) + 3;
  localparam logic [LW-1:0] LAT = LW'(XLEN + 1);

  logic          cap_word, cap_high, cap_imm;
  logic [LW-1:0] lat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_word <= 1'b0;
      cap_high <= 1'b0;
      cap_imm  <= 1'b0;
      lat_q    <= '0;
    end else if (start && !busy) begin
      cap_word <= is_word & ~use_imm;
      cap_high <= want_high & ~use_imm;
      cap_imm  <= use_imm;
      lat_q    <= '0;
    end else if (busy) begin
      lat_q    <= lat_q + 1'b1;
    end
  end

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // also covers R9: a start while busy never restarts the count
  p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lat_q == LAT));

  p_word_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cap_word) |-> (result[XLEN-1:HALF] == '0));

  p_high_no_ovf_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cap_high) |-> !ovf);

  p_cond_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !cap_imm) |-> ($countones(cond) == 1));

  p_cond_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !cap_imm && !cap_word) |-> (cond[0] == (result == '0)));

  p_imm_no_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cap_imm) |-> (!ovf && cond == 3'b000));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(result) && $stable(ovf) && $stable(cond)));

endmodule

bind mul_hilo mul_hilo_chk #(.XLEN(XLEN)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .is_word  (is_word),
  .want_high(want_high),
  .use_imm  (use_imm),
  .busy     (busy),
  .done     (done),
  .result   (result),
  .ovf      (ovf),
  .cond     (cond)
);

// File: tb/test_mul_hilo.sv
module test_mul_hilo;

  localparam int CLK_PERIOD = 10;
  localparam int XLEN       = 64;
  localparam int WATCHDOG   = 150000;

  typedef struct {
    logic [63:0] res;
    logic        ovf;
    logic [2:0]  cond;
    string       tag;
    bit          imm;
  } exp_t;

  logic        clk, rst_n, start, is_signed, is_word, want_high, use_imm;
  logic [63:0] src_a, src_b;
  logic [15:0] imm_val;
  logic        busy, done, ovf;
  logic [63:0] result;
  logic [2:0]  cond;

  int   n_chk, n_fail, last_lat;
  exp_t sb_q[$];
  exp_t last_exp;

  mul_hilo #(.XLEN(XLEN), .IMMW(16)) i_mul_hilo (
    .clk(clk), .rst_n(rst_n), .start(start), .is_signed(is_signed),
    .is_word(is_word), .want_high(want_high), .use_imm(use_imm),
    .src_a(src_a), .src_b(src_b), .imm_val(imm_val),
    .busy(busy), .done(done), .result(result), .ovf(ovf), .cond(cond)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [63:0] a, input logic [63:0] b_in,
                                 input logic sgn_in, input logic word_in,
                                 input logic high_in, input logic imm,
                                 input logic [15:0] iv, input string tag);
    exp_t e;
    logic sgn, word, high;
    logic [63:0] b, r;
    logic signed [127:0] ea, eb, p;
    logic signed [63:0] cv;
    sgn = sgn_in; word = word_in; high = high_in; b = b_in;
    if (imm) begin
      sgn = 1'b1; word = 1'b0; high = 1'b0;
      b = {{48{iv[15]}}, iv};
    end
    if (word) begin
      ea = sgn ? 128'($signed(a[31:0])) : {96'b0, a[31:0]};
      eb = sgn ? 128'($signed(b[31:0])) : {96'b0, b[31:0]};
    end else begin
      ea = sgn ? 128'($signed(a)) : {64'b0, a};
      eb = sgn ? 128'($signed(b)) : {64'b0, b};
    end
    p = ea * eb;
    if (word) r = high ? {32'b0, p[63:32]} : {32'b0, p[31:0]};
    else      r = high ? p[127:64] : p[63:0];
    if (high || imm)     e.ovf = 1'b0;
    else if (word && sgn)  e.ovf = (p > 128'sd2147483647) || (p < -128'sd2147483648);
    else if (word)         e.ovf = ($unsigned(p) > 128'hFFFF_FFFF);
    else if (sgn)          e.ovf = (p > 128'sh7FFF_FFFF_FFFF_FFFF) ||
                                   (p < -128'sh8000_0000_0000_0000);
    else                   e.ovf = ($unsigned(p) > 128'hFFFF_FFFF_FFFF_FFFF);
    cv = word ? 64'($signed(r[31:0])) : $signed(r);
    e.cond = imm ? 3'b000 : {cv < 0, cv > 0, cv == 0};
    e.res  = r;
    e.tag  = tag;
    e.imm  = imm;
    return e;
  endfunction

  // driver: one request, optionally poked by a start while busy (R9)
  task automatic run_op(input logic [63:0] a, input logic [63:0] b,
                        input logic sgn, input logic word, input logic high,
                        input logic imm, input logic [15:0] iv,
                        input string tag, input bit poke);
    int n;
    while (busy) @(negedge clk);
    last_exp = model(a, b, sgn, word, high, imm, iv, tag);
    sb_q.push_back(last_exp);
    src_a = a; src_b = b; is_signed = sgn; is_word = word;
    want_high = high; use_imm = imm; imm_val = iv; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 1;
    if (poke) begin
      src_a = ~a; src_b = b ^ 64'h5A5A_A5A5_0F0F_F0F0; is_signed = ~sgn;
      is_word = ~word; want_high = ~high; use_imm = ~imm; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      n++;
    end
    while (!done) begin
      @(negedge clk);
      n++;
    end
    last_lat = n;
  endtask

  // monitor: compares each completed result with the queue head
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R8", "done without request", 64'd1, 64'd0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check(result == e.res, e.tag, "result", result, e.res);
        check(ovf == e.ovf, e.imm ? "R7" : "R5", "ovf", {63'b0, ovf}, {63'b0, e.ovf});
        check(cond == e.cond, e.imm ? "R7" : "R6", "cond", {61'b0, cond}, {61'b0, e.cond});
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R8 watchdog: actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] corners [7];
    string tg;
    corners = '{64'h0, 64'h1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000,
                64'h7FFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_8000_0000,
                64'h0000_0000_7FFF_FFFF};
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; start = 1'b0; is_signed = 1'b0; is_word = 1'b0;
    want_high = 1'b0; use_imm = 1'b0; src_a = '0; src_b = '0; imm_val = '0;
    repeat (3) @(negedge clk);
    // R11: reset state
    check(busy == 1'b0 && done == 1'b0, "R11", "busy/done in reset",
          {62'b0, busy, done}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 1'b0 && done == 1'b0, "R11", "busy/done after reset",
          {62'b0, busy, done}, 64'd0);
    check(result == 64'd0, "R11", "result after reset", result, 64'd0);
    check(ovf == 1'b0 && cond == 3'b000, "R11", "flags after reset",
          {60'b0, ovf, cond}, 64'd0);

    // R8: latency and single pulse
    run_op(64'd7, 64'd9, 1'b1, 1'b0, 1'b0, 1'b0, 16'd0, "R4", 1'b0);
    check(last_lat == XLEN + 2, "R8", "latency (falling edges)",
          64'(last_lat), 64'(XLEN + 2));
    @(negedge clk);
    check(done == 1'b0 && busy == 1'b0, "R8", "done single cycle",
          {62'b0, busy, done}, 64'd0);

    // R10: result held while idle
    repeat (5) @(negedge clk);
    check(result == last_exp.res, "R10", "result held", result, last_exp.res);

    // corner operand sweep over all eight form combinations
    for (int m = 0; m < 8; m++) begin
      for (int i = 0; i < 7; i++) begin
        for (int j = 0; j < 7; j++) begin
          logic wd, hi;
          wd = m[1]; hi = m[2];
          tg = wd ? (hi ? "R2" : "R1") : (hi ? "R3" : "R4");
          run_op(corners[i] ^ (wd ? {32'hDEAD_BEEF, 32'h0} : 64'h0), corners[j],
                 m[0], wd, hi, 1'b0, 16'd0, tg, 1'b0);
        end
      end
    end

    // random operands with random upper bits on word forms
    for (int k = 0; k < 48; k++) begin
      logic [2:0] m;
      m = 3'($urandom);
      tg = m[1] ? (m[2] ? "R2" : "R1") : (m[2] ? "R3" : "R4");
      run_op({$urandom, $urandom}, {$urandom, $urandom}, m[0], m[1], m[2],
             1'b0, 16'd0, tg, 1'b0);
    end

    // R9: start pulses while busy are ignored
    for (int k = 0; k < 6; k++) begin
      run_op({$urandom, $urandom}, {$urandom, $urandom}, k[0], k[1], k[2],
             1'b0, 16'd0, "R9", 1'b1);
      check(last_lat == XLEN + 2, "R9", "latency with start while busy",
            64'(last_lat), 64'(XLEN + 2));
    end

    // R7: immediate form, src_b and selects ignored
    run_op(64'h8000_0000_0000_0000, 64'h1234, 1'b0, 1'b1, 1'b1, 1'b1,
           16'hFFFF, "R7", 1'b0);
    run_op(64'h7FFF_FFFF_FFFF_FFFF, 64'hFFFF, 1'b0, 1'b0, 1'b1, 1'b1,
           16'h7FFF, "R7", 1'b0);
    run_op(64'h0, {$urandom, $urandom}, 1'b1, 1'b1, 1'b0, 1'b1,
           16'h8000, "R7", 1'b0);
    for (int k = 0; k < 8; k++) begin
      run_op({$urandom, $urandom}, {$urandom, $urandom}, k[0], k[1], k[2], 1'b1,
             16'($urandom), "R7", 1'b0);
    end

    repeat (4) @(negedge clk);
    check(sb_q.size() == 0, "R8", "every request completed",
          64'(sb_q.size()), 64'd0);
    check(result == last_exp.res, "R10", "final result held", result, last_exp.res);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule